// File: doc/BRIEF.md
# Reference clock failsafe monitor

This block lives in the local, crystal-derived clock domain. It decides whether an external reference clock can be trusted to steer the local oscillator. The reference is synchronized and edge-detected, then divided by a ratio picked with two select inputs. The block measures how many local clock cycles fit into a fixed number of divided-reference periods. If that count falls inside a ppm tolerance band around its nominal value, the reference is accepted and a digital tuning code steps one count toward zero frequency error. The code drives an external capacitor array, which is outside this block.

When the reference stops, or its divided frequency leaves the capture band, the tuning code is frozen at its last value and an active-low fail flag is driven low. The local oscillator always keeps running from that frozen code. The block never hands the output over to another source, so losing the reference cannot cause a glitch. After the reference returns to the band, the flag is released only after a hold-off. The hold-off counts twelve reference edges for each step of the selected ratio, followed by a fixed guard time.

Top module: `refclk_failsafe`

## Requirements
- R1: While reset is asserted and right after it is released, fail_n_o is 0 and tune_code_o is at mid-scale (2^(TUNE_W-1)).
- R2: ratio_sel selects the divide ratio n as 00→1, 01→2, 10→4, 11→8. A reference at n times the nominal divided frequency is accepted for each of the four codes, and one that matches a different code is rejected.
- R3: A measurement spans WIN_PERIODS divided-reference periods. It is accepted when the local cycle count lies within NOM_CYC·WIN_PERIODS ± floor(NOM_CYC·WIN_PERIODS·TOL_PPM/10^6). A stream of accepted measurements drives fail_n_o to 1, and a fail_n_o rise never happens while the reference is flagged lost.
- R4: A measurement outside the band drives fail_n_o to 0 on the next cycle and leaves tune_code_o unchanged. The flag rises again after an accepted measurement.
- R5: When no divided-reference edge arrives within 2·NOM_CYC local cycles, the reference is lost: fail_n_o is 0 from the following cycle, and tune_code_o holds its value for as long as the reference stays away.
- R6: After the measurement that re-accepts the reference, fail_n_o stays 0 until at least 12·n synchronized reference rising edges have been seen, and then for GUARD_CYC more local cycles.
- R7: An accepted measurement with a count above nominal lowers tune_code_o by one. One below nominal raises it by one. An exact nominal count leaves it unchanged.
- R8: tune_code_o saturates at 0 and at 2^TUNE_W−1 and never wraps.
- R9: tune_code_o changes only on the cycle after an accepted measurement, and only by one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local crystal-derived clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | External reference clock, asynchronous to clk |
| ratio_sel | input | 2 | Reference-to-crystal ratio select |
| tune_code_o | output | TUNE_W | Oscillator tuning code |
| fail_n_o | output | 1 | Reference status, 0 = failed or not yet valid |

## Verification
On every cycle the assertions check several properties of the tuning code and the flag. The code moves only after an accepted window, by a single step, and never wraps. A rejected window or a lost reference pulls the flag low on the very next cycle. Each rise of the flag comes after at least 12·n reference edges since the last window and never while the reference is lost. Other behaviour can only be seen in the bench scenarios: which frequencies land inside or outside the band for each ratio code, the direction the code drifts for a slow or fast reference, the end-to-end delay from reset to flag release, and recovery after a stop or an out-of-band drift.

// File: rtl/refclk_fs_pkg.sv
// Shared types and helpers for the reference clock failsafe monitor.
// Assumes the ratio select is a two-bit binary exponent of the divide ratio.
package refclk_fs_pkg;

    typedef enum logic [1:0] {
        FS_FAIL       = 2'd0,
        FS_EDGE_WAIT  = 2'd1,
        FS_GUARD_WAIT = 2'd2,
        FS_GOOD       = 2'd3
    } fs_state_t;

    // Decode the two select bits into the divide ratio 1, 2, 4 or 8.
    function automatic logic [3:0] ratio_of(input logic [1:0] sel);
        return 4'd1 << sel;
    endfunction

endpackage

// File: rtl/refclk_edge_sync.sv
// Brings the asynchronous reference into the local clock domain through a
// flop chain and flags each rising edge with a one-cycle pulse.
// Assumes every reference high and low phase spans at least one local clock.
module refclk_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Metastability chain followed by one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/refclk_divider.sv
// Divides the synchronized reference edge stream by the selected ratio and
// emits one tick per divided period. A select change restarts the count.
// Assumes the select inputs are quasi-static.
module refclk_divider
    import refclk_fs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    logic [2:0] edge_cnt;
    logic [1:0] sel_q;
    logic [2:0] last_cnt;

    assign last_cnt = 3'(ratio_of(sel_i) - 4'd1);
    assign tick_o   = rise_i && (edge_cnt == last_cnt) && (sel_i == sel_q);

    // Count reference edges modulo the ratio; restart when the select moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            sel_q    <= '0;
        end else begin
            sel_q <= sel_i;
            if (sel_i != sel_q) begin
                edge_cnt <= '0;
            end else if (rise_i) begin
                edge_cnt <= (edge_cnt == last_cnt) ? 3'd0 : edge_cnt + 3'd1;
            end
        end
    end
endmodule

// File: rtl/refclk_freq_meter.sv
// Counts local cycles across WIN_PERIODS divided-reference periods and
// compares the total against a ppm band fixed at elaboration. It also flags
// a lost reference when no divided tick arrives within twice the nominal
// period. Assumes WIN_PERIODS >= 16 and NOM_CYC >= 4.
module refclk_freq_meter #(
    parameter int NOM_CYC     = 32,
    parameter int WIN_PERIODS = 4096,
    parameter int TOL_PPM     = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic win_done_o,
    output logic win_ok_o,
    output logic win_fast_o,
    output logic win_slow_o,
    output logic ref_lost_o
);
    localparam int NOM_TOTAL = NOM_CYC * WIN_PERIODS;
    localparam int TOL_CNT   = int'((longint'(NOM_TOTAL) * longint'(TOL_PPM)) / longint'(1000000));
    localparam int HI_CNT    = NOM_TOTAL + TOL_CNT;
    localparam int LO_CNT    = NOM_TOTAL - TOL_CNT;
    localparam int LOST_LIM  = 2 * NOM_CYC;
    localparam int CNT_W     = $clog2(2 * NOM_TOTAL + 2);
    localparam int GAP_W     = $clog2(LOST_LIM + 1);
    localparam int PER_W     = $clog2(WIN_PERIODS + 1);

    logic             active;
    logic [CNT_W-1:0] cyc_cnt;
    logic [CNT_W-1:0] meas;
    logic [PER_W-1:0] per_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic             last_tick;

    assign ref_lost_o = (gap_cnt == GAP_W'(LOST_LIM));
    assign meas       = cyc_cnt + 1'b1;
    assign last_tick  = tick_i && active && (per_cnt == PER_W'(WIN_PERIODS - 1));

    // Cycles since the last divided tick, saturating at the loss limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (tick_i) begin
            gap_cnt <= '0;
        end else if (!ref_lost_o) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // Window sequencer: start on a tick, count cycles, close after N periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cyc_cnt <= '0;
            per_cnt <= '0;
        end else if (ref_lost_o) begin
            active  <= 1'b0;
            cyc_cnt <= '0;
            per_cnt <= '0;
        end else if (tick_i) begin
            if (!active || last_tick) begin
                active  <= 1'b1;
                cyc_cnt <= '0;
                per_cnt <= '0;
            end else begin
                cyc_cnt <= cyc_cnt + 1'b1;
                per_cnt <= per_cnt + 1'b1;
            end
        end else if (active) begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    // Register the verdict of each completed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_done_o <= 1'b0;
            win_ok_o   <= 1'b0;
            win_fast_o <= 1'b0;
            win_slow_o <= 1'b0;
        end else begin
            win_done_o <= last_tick && !ref_lost_o;
            if (last_tick) begin
                win_ok_o   <= (meas >= CNT_W'(LO_CNT)) && (meas <= CNT_W'(HI_CNT));
                win_fast_o <= (meas > CNT_W'(NOM_TOTAL));
                win_slow_o <= (meas < CNT_W'(NOM_TOTAL));
            end
        end
    end
endmodule

// File: rtl/refclk_tune_ctrl.sv
// Owns the tuning code and the active-low fail flag. The code steps one
// count per accepted window and freezes otherwise. The flag is released
// only after 12*n reference edges plus GUARD_CYC cycles of hold-off.
// Assumes window verdict inputs are one-cycle pulses with stable levels.
module refclk_tune_ctrl
    import refclk_fs_pkg::*;
#(
    parameter int TUNE_W    = 8,
    parameter int GUARD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_done_i,
    input  logic              win_ok_i,
    input  logic              win_fast_i,
    input  logic              win_slow_i,
    input  logic              ref_lost_i,
    input  logic              ref_rise_i,
    input  logic [1:0]        sel_i,
    output logic [TUNE_W-1:0] code_o,
    output logic              fail_n_o
);
    localparam logic [TUNE_W-1:0] CODE_MID = TUNE_W'(1) << (TUNE_W - 1);
    localparam logic [TUNE_W-1:0] CODE_MAX = '1;
    localparam int                GUARD_W  = $clog2(GUARD_CYC + 1);

    fs_state_t          state, nxt;
    logic [6:0]         edge_cnt;
    logic [6:0]         edge_last;
    logic [GUARD_W-1:0] guard_cnt;
    logic               accept;

    assign edge_last = 7'(12 * ratio_of(sel_i) - 1);
    assign accept    = win_done_i && win_ok_i && !ref_lost_i;

    // Next-state choice; loss and rejected windows override everything.
    always_comb begin
        nxt = state;
        case (state)
            FS_FAIL:       if (accept) nxt = FS_EDGE_WAIT;
            FS_EDGE_WAIT:  if (ref_rise_i && edge_cnt == edge_last) nxt = FS_GUARD_WAIT;
            FS_GUARD_WAIT: if (guard_cnt == GUARD_W'(GUARD_CYC - 1)) nxt = FS_GOOD;
            default:       nxt = state;
        endcase
        if (win_done_i && !win_ok_i) nxt = FS_FAIL;
        if (ref_lost_i)              nxt = FS_FAIL;
    end

    // State, hold-off counters and the registered flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FS_FAIL;
            edge_cnt  <= '0;
            guard_cnt <= '0;
            fail_n_o  <= 1'b0;
        end else begin
            state     <= nxt;
            fail_n_o  <= (nxt == FS_GOOD);
            edge_cnt  <= (state == FS_EDGE_WAIT && ref_rise_i) ? edge_cnt + 7'd1 :
                         (state == FS_EDGE_WAIT) ? edge_cnt : 7'd0;
            guard_cnt <= (state == FS_GUARD_WAIT) ? guard_cnt + 1'b1 : '0;
        end
    end

    // Step the tuning code toward zero error, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= CODE_MID;
        end else if (accept) begin
            if (win_fast_i && code_o != '0)
                code_o <= code_o - 1'b1;
            else if (win_slow_i && code_o != CODE_MAX)
                code_o <= code_o + 1'b1;
        end
    end
endmodule

// File: rtl/refclk_failsafe.sv
// Top of the reference clock failsafe monitor. It chains the synchronizer,
// the ratio divider, the frequency meter and the tuning controller. The
// reference is only observed and never routed to any output.
// Assumes clk is the free-running local oscillator clock.
module refclk_failsafe #(
    parameter int NOM_CYC     = 32,
    parameter int WIN_PERIODS = 4096,
    parameter int TOL_PPM     = 300,
    parameter int TUNE_W      = 8,
    parameter int GUARD_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk_i,
    input  logic [1:0]        ratio_sel,
    output logic [TUNE_W-1:0] tune_code_o,
    output logic              fail_n_o
);
    logic ref_rise;
    logic div_tick;
    logic win_done, win_ok, win_fast, win_slow, ref_lost;

    refclk_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_clk_i),
        .rise_o   (ref_rise)
    );

    refclk_divider u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (ref_rise),
        .sel_i  (ratio_sel),
        .tick_o (div_tick)
    );

    refclk_freq_meter #(
        .NOM_CYC     (NOM_CYC),
        .WIN_PERIODS (WIN_PERIODS),
        .TOL_PPM     (TOL_PPM)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (div_tick),
        .win_done_o (win_done),
        .win_ok_o   (win_ok),
        .win_fast_o (win_fast),
        .win_slow_o (win_slow),
        .ref_lost_o (ref_lost)
    );

    refclk_tune_ctrl #(
        .TUNE_W    (TUNE_W),
        .GUARD_CYC (GUARD_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_done_i (win_done),
        .win_ok_i   (win_ok),
        .win_fast_i (win_fast),
        .win_slow_i (win_slow),
        .ref_lost_i (ref_lost),
        .ref_rise_i (ref_rise),
        .sel_i      (ratio_sel),
        .code_o     (tune_code_o),
        .fail_n_o   (fail_n_o)
    );
endmodule

// File: rtl/refclk_failsafe_chk.sv
// Property checker for the failsafe monitor, attached to the top by bind.
// Assumes WIN_PERIODS is large enough that no window closes inside hold-off.
module refclk_failsafe_chk #(
    parameter int TUNE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        sel,
    input logic [TUNE_W-1:0] code,
    input logic              fail_n,
    input logic              win_done,
    input logic              win_ok,
    input logic              ref_lost,
    input logic              ref_rise
);
    logic [7:0] rises_since_win;

    // Reference edges seen since the most recent window verdict.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rises_since_win <= '0;
        else if (win_done)
            rises_since_win <= '0;
        else if (ref_rise && rises_since_win != 8'hFF)
            rises_since_win <= rises_since_win + 8'd1;
    end

    a_r4_bad_window_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !win_ok) |=> !fail_n);

    a_r5_lost_fails: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lost |=> !fail_n);

    a_r6_clear_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_n) |-> (int'(rises_since_win) >= 12 * (1 << sel)));

    a_r3_clear_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_n) |-> !ref_lost);

    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> ((int'(code) == int'($past(code)) + 1) ||
                            (int'(code) == int'($past(code)) - 1)));

    a_r9_only_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> $past(win_done && win_ok));

    a_r8_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '1) |=> (code != '0));

    a_r8_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |=> (code != '1));
endmodule

bind refclk_failsafe refclk_failsafe_chk #(.TUNE_W(TUNE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (ratio_sel),
    .code     (tune_code_o),
    .fail_n   (fail_n_o),
    .win_done (win_done),
    .win_ok   (win_ok),
    .ref_lost (ref_lost),
    .ref_rise (ref_rise)
);

// File: tb/sim_refclk_failsafe.sv
module sim_refclk_failsafe;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NOM     = 32;
    localparam int WIN     = 64;
    localparam int TOLP    = 5000;
    localparam int TW      = 3;
    localparam int GUARD   = 4;
    localparam int MID     = 1 << (TW - 1);
    localparam int MAXC    = (1 << TW) - 1;
    localparam int WIN_CYC = NOM * WIN;
    localparam int NVEC    = 10;

    // Vector table: select code, divided-reference period in ps, expected
    // flag, expected code direction (-1 below mid, +1 above mid, 0 unchecked).
    localparam logic [1:0] V_SEL [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1,
                                            2'd2, 2'd0, 2'd3, 2'd2, 2'd0};
    localparam int V_PS  [NVEC] = '{256000, 256000, 256000, 256000, 256768,
                                    255232, 261120, 250880, 253440, 64000};
    localparam bit V_OK  [NVEC] = '{1, 1, 1, 1, 1, 1, 0, 0, 0, 0};
    localparam int V_DIR [NVEC] = '{0, 0, 0, 0, -1, 1, 0, 0, 0, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_clk = 1'b0;
    logic [1:0]    sel = 2'd0;
    logic [TW-1:0] code;
    logic          fail_n;

    bit      ref_run = 1'b0;
    realtime half_ns = 128.0;
    int      n_tests = 0;
    int      n_fail  = 0;
    int      cyc     = 0;

    refclk_failsafe #(
        .NOM_CYC     (NOM),
        .WIN_PERIODS (WIN),
        .TOL_PPM     (TOLP),
        .TUNE_W      (TW),
        .GUARD_CYC   (GUARD)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_clk_i   (ref_clk),
        .ratio_sel   (sel),
        .tune_code_o (code),
        .fail_n_o    (fail_n)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference generator; a stopped reference parks low with no extra edge.
    initial begin
        forever begin
            if (ref_run) begin
                #(half_ns);
                if (ref_run) ref_clk = ~ref_clk;
                else         ref_clk = 1'b0;
            end else begin
                ref_clk = 1'b0;
                #(0.7);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_ref(input logic [1:0] s, input int div_ps);
        sel     = s;
        half_ns = real'(div_ps) / (2000.0 * real'(1 << s));
        ref_run = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int t0, dt, c1;
        // R1: reset state.
        @(negedge clk);
        check(fail_n == 1'b0, "R1 flag in reset", int'(fail_n), 0);
        check(int'(code) == MID, "R1 code in reset", int'(code), MID);
        set_ref(2'd0, 256000);
        do_reset();
        wait_cyc(3);
        check(fail_n == 1'b0, "R1 flag after release", int'(fail_n), 0);
        check(int'(code) == MID, "R1 code after release", int'(code), MID);

        // Table walk: R2 ratio codes, R3 band acceptance, R4 rejection, R7 direction.
        for (int i = 0; i < NVEC; i++) begin
            set_ref(V_SEL[i], V_PS[i]);
            do_reset();
            wait_cyc(3 * WIN_CYC + 1000);
            check(fail_n == V_OK[i], V_OK[i] ? "R2/R3 accepted" : "R2/R4 rejected",
                  int'(fail_n), int'(V_OK[i]));
            if (!V_OK[i])
                check(int'(code) == MID, "R4 code frozen", int'(code), MID);
            if (V_DIR[i] < 0)
                check(int'(code) < MID, "R7 slow ref lowers code", int'(code), MID - 1);
            if (V_DIR[i] > 0)
                check(int'(code) > MID, "R7 fast ref raises code", int'(code), MID + 1);
        end

        // R6: reset-to-release delay for the smallest and largest ratio.
        for (int k = 0; k < 2; k++) begin
            set_ref(k == 0 ? 2'd3 : 2'd0, 256000);
            do_reset();
            t0 = cyc;
            for (int j = 0; j < 8000 && fail_n !== 1'b1; j++) @(negedge clk);
            dt = cyc - t0;
            check(dt >= WIN_CYC + 11 * NOM + GUARD, "R6 hold-off lower bound", dt,
                  WIN_CYC + 11 * NOM + GUARD);
            check(dt <= WIN_CYC + 12 * NOM + 100, "R6 hold-off upper bound", dt,
                  WIN_CYC + 12 * NOM + 100);
        end

        // R5: stopped reference drops the flag and holds the code.
        c1 = int'(code);
        ref_run = 1'b0;
        wait_cyc(2 * NOM + 16);
        check(fail_n == 1'b0, "R5 flag after stop", int'(fail_n), 0);
        check(int'(code) == c1, "R5 code held", int'(code), c1);
        wait_cyc(WIN_CYC + 100);
        check(int'(code) == c1, "R5 code held long", int'(code), c1);
        set_ref(2'd0, 256000);
        wait_cyc(2 * WIN_CYC + 600);
        check(fail_n == 1'b1, "R3 recovery after stop", int'(fail_n), 1);

        // R4: drift out of band while running, then return.
        set_ref(2'd0, 261120);
        wait_cyc(2 * WIN_CYC + 200);
        check(fail_n == 1'b0, "R4 flag after drift", int'(fail_n), 0);
        c1 = int'(code);
        wait_cyc(WIN_CYC + 100);
        check(int'(code) == c1, "R4 code frozen while out of band", int'(code), c1);
        check(fail_n == 1'b0, "R4 flag stays low", int'(fail_n), 0);
        set_ref(2'd0, 256000);
        wait_cyc(3 * WIN_CYC + 500);
        check(fail_n == 1'b1, "R4 flag clears on return", int'(fail_n), 1);

        // R9/R7: one step after the first accepted window; R8 saturation.
        set_ref(2'd1, 255232);
        do_reset();
        wait_cyc(WIN_CYC + WIN_CYC / 2);
        check(int'(code) == MID + 1, "R9 single step after first window", int'(code), MID + 1);
        wait_cyc(5 * WIN_CYC);
        check(int'(code) == MAXC, "R8 saturate high", int'(code), MAXC);
        set_ref(2'd1, 256768);
        wait_cyc(10 * WIN_CYC);
        check(int'(code) == 0, "R8 saturate low", int'(code), 0);
        check(fail_n == 1'b1, "R3 flag held while tracking", int'(fail_n), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as one failed check.
    initial begin
        repeat (195000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 195000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule